// File: doc/BRIEF.md
# Atomic Memory Operation and Reservation Unit

This block carries out 32-bit atomic operations against a synchronous word memory with one cycle of read latency. It handles three kinds of request. A load-reserved reads a word and arms a single reservation. A store-conditional writes a word only when that reservation covers its address. Nine read-modify-write operations return the old memory word and store a combined value. The reservation is one register: a valid bit and a byte address.

A request is a stream beat. Its fields are taken when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is high only while the unit is idle, so a requester that holds `req_valid` waits, with its fields held or changed freely, until the current operation has finished. The response is a single-cycle `rsp_valid` pulse. It carries the destination value and a fault flag. The response cannot be back-pressured, so the consumer must take it in that cycle. The memory port is a plain read/write strobe pair with a shared address, and read data is returned on the cycle after the read strobe.

Top module: `amo_unit`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when the unit is idle, including right after reset. It stays low from acceptance through the response cycle. `rsp_valid` is high for exactly one cycle per accepted request.
- R2: Load-reserved (opcode 0) returns the addressed memory word in `rsp_data`. It records the address as a valid reservation. Its response comes in the third cycle after the accepting cycle, and it makes no memory write.
- R3: Store-conditional (opcode 1) succeeds when the reservation is valid and holds exactly the request address. On success it writes `req_src` to that address, returns 0, and responds in the second cycle after acceptance.
- R4: A store-conditional that fails returns 1, performs no memory write, and responds in the first cycle after acceptance.
- R5: Every aligned, legal store-conditional leaves the reservation invalid, whether it succeeds or fails. After reset the reservation is invalid.
- R6: Read-modify-write opcodes return the original memory word and write the result to the same address. The codes are: 2 swap (result = src), 3 add (wrapping), 4 xor, 5 and, and 6 or.
- R7: Opcodes 7 and 8 store the signed minimum and signed maximum of the memory word and src. Opcodes 9 and 10 store the unsigned minimum and unsigned maximum.
- R8: A read-modify-write reads in the first cycle after acceptance. It writes to the same address in the third cycle, with no other memory access in between, and responds in the fourth cycle.
- R9: The two ordering bits `req_order` have no effect on any result, timing or memory contents.
- R10: An address whose two low bits are not zero gives `rsp_fault`=1 and `rsp_data`=0 in the first cycle after acceptance. It causes no memory access and leaves the reservation unchanged.
- R11: Opcodes 11 to 15 are treated as illegal and are handled like R10: a fault response, no memory access, and no change to the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 4 | Operation code |
| req_order | input | 2 | Ordering hints, ignored |
| req_addr | input | ADDR_W | Byte address of the word |
| req_src | input | DATA_W | Source operand |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Value for the destination register |
| rsp_fault | output | 1 | Misaligned address or illegal opcode |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the strobe |

## Verification
The write-back of a read-modify-write, or of a successful store-conditional, can fall in the same cycle as a new request held on the input. The bench provokes this on every operation: it keeps `req_valid` high with a random opcode for the whole time the unit is busy. It then judges that `req_ready` stays low until the response, that only the intended write reaches the memory image, and that the response latency matches the operation's class. A second overlap comes when a store-conditional's reservation check and its clear happen in the accepting cycle. This is judged by issuing a store-conditional twice in a row, and by a failed store-conditional followed by a matching one.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    OP_LR   = 4'd0,
    OP_SC   = 4'd1,
    OP_SWAP = 4'd2,
    OP_ADD  = 4'd3,
    OP_XOR  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_MIN  = 4'd7,
    OP_MAX  = 4'd8,
    OP_MINU = 4'd9,
    OP_MAXU = 4'd10
  } amo_op_e;

  localparam logic [3:0] OP_LAST = 4'd10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_COMPUTE,
    ST_WRITE,
    ST_DONE
  } amo_state_e;

  function automatic logic op_is_rmw(input logic [3:0] op);
    return (op >= OP_SWAP) && (op <= OP_LAST);
  endfunction
endpackage

// File: rtl/amo_alu.sv
module amo_alu #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] mem_val,
  input  logic [W-1:0] src,
  output logic [W-1:0] result
);
  import amo_pkg::*;

  logic s_lt, u_lt;
  assign s_lt = $signed(mem_val) < $signed(src);
  assign u_lt = mem_val < src;

  always_comb begin
    case (op)
      OP_ADD:  result = mem_val + src;
      OP_XOR:  result = mem_val ^ src;
      OP_AND:  result = mem_val & src;
      OP_OR:   result = mem_val | src;
      OP_MIN:  result = s_lt ? mem_val : src;
      OP_MAX:  result = s_lt ? src : mem_val;
      OP_MINU: result = u_lt ? mem_val : src;
      OP_MAXU: result = u_lt ? src : mem_val;
      default: result = src;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          clr,
  input  logic [AW-1:0] chk_addr,
  output logic          hit,
  output logic          held
);
  logic          v_q;
  logic [AW-1:0] a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
    end else if (set) begin
      v_q <= 1'b1;
      a_q <= set_addr;
    end else if (clr) begin
      v_q <= 1'b0;
    end
  end

  assign hit  = v_q && (a_q == chk_addr);
  assign held = v_q;

  // R5: arm and clear come from different FSM states, never together
  p_set_clr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(set && clr));
  // R5: a clear request leaves no live reservation next cycle
  p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !held);
endmodule

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [1:0]        req_order,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_src,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_fault,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  import amo_pkg::*;

  localparam int ALIGN_BITS = 2;

  amo_state_e        state_q;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, wr_q, dest_q;
  logic              fault_q;

  logic              accept, req_bad, is_sc, rsv_hit, rsv_held, rsv_set, rsv_clr;
  logic [DATA_W-1:0] alu_out;
  logic              order_unused;

  assign order_unused = ^req_order;
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign req_bad = (req_addr[ALIGN_BITS-1:0] != '0) || (req_op > OP_LAST);
  assign is_sc   = (req_op == OP_SC);
  assign rsv_clr = accept && is_sc && !req_bad;
  assign rsv_set = (state_q == ST_COMPUTE) && (op_q == OP_LR);

  amo_resv #(.AW(ADDR_W)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (rsv_set),
    .set_addr (addr_q),
    .clr      (rsv_clr),
    .chk_addr (req_addr),
    .hit      (rsv_hit),
    .held     (rsv_held)
  );

  amo_alu #(.W(DATA_W)) u_alu (
    .op      (op_q),
    .mem_val (mem_rdata),
    .src     (src_q),
    .result  (alu_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      wr_q    <= '0;
      dest_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          src_q   <= req_src;
          wr_q    <= req_src;
          fault_q <= req_bad;
          dest_q  <= '0;
          if (req_bad) begin
            state_q <= ST_DONE;
          end else if (is_sc) begin
            dest_q  <= rsv_hit ? DATA_W'(0) : DATA_W'(1);
            state_q <= rsv_hit ? ST_WRITE : ST_DONE;
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_COMPUTE;
        ST_COMPUTE: begin
          dest_q <= mem_rdata;
          if (op_q == OP_LR) begin
            state_q <= ST_DONE;
          end else begin
            wr_q    <= alu_out;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_data  = dest_q;
  assign rsp_fault = (state_q == ST_DONE) && fault_q;
  assign mem_rd_en = (state_q == ST_READ);
  assign mem_wr_en = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wr_q;

  // R1: no memory traffic while the unit is open for a new request
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mem_rd_en || mem_wr_en));
  // R1: response is a single-cycle pulse
  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2: a load-reserved arms the reservation once its data is back
  p_lr_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMPUTE && op_q == OP_LR) |=> rsv_held);
  // R4: a missed store-conditional answers 1 next cycle with no write
  p_sc_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_clr && !rsv_hit) |=> (rsp_valid && rsp_data == DATA_W'(1) && !mem_wr_en));
  // R5: an accepted store-conditional drops the reservation
  p_sc_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_clr |=> !rsv_held);
  // R8: read data is followed straight by the write to the same address
  p_rmw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMPUTE && op_q != OP_LR) |=> (mem_wr_en && !mem_rd_en && $stable(mem_addr)));
  // R10: a bad request answers at once with a fault and touches nothing
  p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_bad) |=> (rsp_valid && rsp_fault && !mem_wr_en && !mem_rd_en && $stable(rsv_held)));
endmodule

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_order = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_src = '0;
  logic        rsp_valid, rsp_fault, mem_rd_en, mem_wr_en;
  logic [31:0] rsp_data, mem_addr, mem_wdata;
  logic [31:0] mem_rdata;

  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  logic        ref_rv;
  logic [31:0] ref_ra;
  int          wr_cnt = 0;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  always #5 clk = ~clk;

  amo_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_order(req_order), .req_addr(req_addr), .req_src(req_src),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:2]];
    if (mem_wr_en) begin
      mem[mem_addr[7:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: got %0d cycles exp below 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_alu(input logic [3:0] op, input logic [31:0] m, input logic [31:0] s);
    case (op)
      4'd3:  return m + s;
      4'd4:  return m ^ s;
      4'd5:  return m & s;
      4'd6:  return m | s;
      4'd7:  return ($signed(m) < $signed(s)) ? m : s;
      4'd8:  return ($signed(m) > $signed(s)) ? m : s;
      4'd9:  return (m < s) ? m : s;
      4'd10: return (m > s) ? m : s;
      default: return s;
    endcase
  endfunction

  task automatic do_op(input string tag, input logic [3:0] op, input logic [1:0] ord,
                       input logic [31:0] addr, input logic [31:0] src);
    logic        is_bad = (addr[1:0] != 2'b00) || (op > 4'd10);
    int          idx = int'(addr[7:2]);
    logic [31:0] old = ref_mem[idx];
    logic [31:0] exp_data;
    int          exp_lat, exp_wr, lat, wr0;
    logic        ready_err = 1'b0;
    if (is_bad) begin
      exp_data = 0; exp_lat = 1; exp_wr = 0;
    end else if (op == 4'd0) begin
      exp_data = old; exp_lat = 3; exp_wr = 0;
      ref_rv = 1'b1; ref_ra = addr;
    end else if (op == 4'd1) begin
      if (ref_rv && ref_ra == addr) begin
        exp_data = 0; exp_lat = 2; exp_wr = 1; ref_mem[idx] = src;
      end else begin
        exp_data = 1; exp_lat = 1; exp_wr = 0;
      end
      ref_rv = 1'b0;
    end else begin
      exp_data = old; exp_lat = 4; exp_wr = 1; ref_mem[idx] = ref_alu(op, old, src);
    end
    @(negedge clk);
    check({tag, " ready before request (R1)"}, {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_op = op; req_order = ord; req_addr = addr; req_src = src;
    wr0 = wr_cnt;
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      req_op = 4'($urandom_range(0, 15));
      req_addr = $urandom;
      req_src = $urandom;
      if (req_ready) ready_err = 1'b1;
    end while (!rsp_valid && lat < 20);
    req_valid = 1'b0;
    check({tag, " ready held low while busy (R1)"}, {31'b0, ready_err}, 32'd0);
    check({tag, " latency"}, lat, exp_lat);
    check({tag, " rsp_data"}, rsp_data, exp_data);
    check({tag, " rsp_fault (R10)"}, {31'b0, rsp_fault}, {31'b0, is_bad});
    @(negedge clk);
    check({tag, " rsp pulse one cycle (R1)"}, {31'b0, rsp_valid}, 32'd0);
    check({tag, " write count"}, wr_cnt - wr0, exp_wr);
    for (int i = 0; i < 64; i++)
      if (mem[i] !== ref_mem[i]) check({tag, " memory image (R8)"}, mem[i], ref_mem[i]);
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic [31:0] addr);
    if (addr[1:0] != 2'b00) return "R10";
    if (op > 4'd10) return "R11";
    if (op == 4'd0) return "R2";
    if (op == 4'd1) return "R3";
    if (op >= 4'd7) return "R7";
    return "R6";
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h9E3779B9 * (i + 1);
      ref_mem[i] = mem[i];
    end
    ref_rv = 1'b0; ref_ra = '0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", {31'b0, req_ready}, 32'd1);
    check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 reset mem strobes", {30'b0, mem_rd_en, mem_wr_en}, 32'd0);
    rst_n = 1'b1;
    // R5: reservation invalid after reset, so SC fails
    do_op("R5 sc after reset", 4'd1, 2'd0, 32'h10, 32'h1111);
    do_op("R2 lr", 4'd0, 2'd0, 32'h10, 32'h0);
    do_op("R3 sc hit", 4'd1, 2'd0, 32'h10, 32'hCAFE0001);
    do_op("R5 sc repeat fails", 4'd1, 2'd0, 32'h10, 32'hCAFE0002);
    do_op("R2 lr", 4'd0, 2'd0, 32'h20, 32'h0);
    do_op("R4 sc other addr", 4'd1, 2'd0, 32'h24, 32'h5);
    do_op("R5 sc after failed sc", 4'd1, 2'd0, 32'h20, 32'h6);
    do_op("R2 lr", 4'd0, 2'd0, 32'h30, 32'h0);
    do_op("R10 misaligned sc", 4'd1, 2'd0, 32'h32, 32'h7);
    do_op("R11 illegal op", 4'd13, 2'd0, 32'h30, 32'h7);
    do_op("R10 reservation kept", 4'd1, 2'd0, 32'h30, 32'h8);
    do_op("R10 misaligned lr", 4'd0, 2'd0, 32'h41, 32'h0);
    do_op("R10 misaligned amo", 4'd3, 2'd0, 32'h43, 32'h1);
    do_op("R6 swap", 4'd2, 2'd0, 32'h40, 32'hA5A5A5A5);
    do_op("R6 add wrap", 4'd3, 2'd0, 32'h40, 32'h5A5A5A5B);
    do_op("R9 add ordered", 4'd3, 2'd3, 32'h40, 32'h00000010);
    do_op("R6 xor", 4'd4, 2'd1, 32'h44, 32'hFFFF0000);
    do_op("R6 and", 4'd5, 2'd2, 32'h44, 32'h0F0F0F0F);
    do_op("R6 or", 4'd6, 2'd0, 32'h44, 32'h80000001);
    do_op("R6 swap setup", 4'd2, 2'd0, 32'h48, 32'h80000000);
    do_op("R7 signed min", 4'd7, 2'd0, 32'h48, 32'h00000001);
    do_op("R7 signed max", 4'd8, 2'd0, 32'h48, 32'h00000001);
    do_op("R6 swap setup", 4'd2, 2'd0, 32'h48, 32'h80000000);
    do_op("R7 unsigned min", 4'd9, 2'd0, 32'h48, 32'h00000001);
    do_op("R6 swap setup", 4'd2, 2'd0, 32'h48, 32'h00000001);
    do_op("R7 unsigned max", 4'd10, 2'd0, 32'h48, 32'hFFFFFFFF);
    do_op("R7 signed max neg", 4'd8, 2'd0, 32'h48, 32'h80000000);
    do_op("R8 amo after lr keeps resv", 4'd0, 2'd0, 32'h50, 32'h0);
    do_op("R8 amo", 4'd3, 2'd0, 32'h54, 32'h3);
    do_op("R3 sc still hits", 4'd1, 2'd0, 32'h50, 32'h77);
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  op;
      logic [31:0] a;
      op = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 1)) : 4'($urandom_range(0, 15));
      a = {24'b0, 2'b0, 4'($urandom_range(0, 7)), 2'b00};
      if ($urandom_range(0, 9) == 0) a[1:0] = 2'($urandom_range(1, 3));
      do_op(tag_of(op, a), op, 2'($urandom), a, $urandom);
    end
    finish_run();
  end
endmodule